// File: doc/BRIEF.md
# Configurable Two-Mux Spare Logic Cell

This block is a reprogrammable spare logic element for late logic fixes. Its core is exactly two 2:1 multiplexer stages in cascade. A static configuration, which stands in for a metal-only change, chooses one of four personalities.

- **Gate mode** builds a general 2- or 3-input gate. Each mux data input is tied to a pin, to the inverted copy of pin `b`, or to a constant.
- **XOR3 mode** builds a three-input exclusive OR.
- **Latch mode** builds a level-sensitive latch.
- **Flop mode** builds a rising-edge D flip-flop. It has a scan input and an asynchronous active-low clear.

In the two storing modes each mux stage holds its value by routing its own output back to one of its data inputs. The flip-flop is a master/slave pair. The first stage is open while the clock is low and the second while it is high.

The configuration is set while the clear pin is low and then left alone. In the sequential modes pin `a` is the functional data input. The small glue around the muxes is limited to three pieces:

- the inverter on `b`;
- an inverter on the first stage's output, used only for XOR3;
- the scan steering of the data input.

Top module: `spareCell`

## Requirements
- R1: With `mode`=0 (gate), stage 0 selects on `a` and stage 1 selects on `c`, and `out` is stage 1's output. `gateCfg[1:0]` and `gateCfg[3:2]` pick stage 0's input for `a`=0 and `a`=1 (0=const 0, 1=const 1, 2=`b`, 3=not `b`). `gateCfg[5:4]` and `gateCfg[7:6]` pick stage 1's input for `c`=0 and `c`=1 (0=const 0, 1=const 1, 2=stage 0 output, 3=`b`).
- R2: With `mode`=1 (XOR3), `out` = `a` xor `b` xor `c`.
- R3: With `mode`=2 (latch) and `clrN` high, `out` follows `a` while `en`=1.
- R4: With `mode`=2, `out` holds its value while `en`=0, whatever `a` does.
- R5: With `mode`=3 (flop), `out` takes `scanIn` when `scanEn`=1, else `a`, on each rising `clk` edge, and does not change between rising edges.
- R6: In latch and flop modes, `clrN` low forces `out` to 0 at once, regardless of `clk` and `en`.
- R7: In gate and XOR3 modes, `clrN` has no effect on `out`.
- R8: `mode` and `gateCfg` change only while `clrN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for flop mode |
| clrN | input | 1 | Active-low asynchronous clear of stored state |
| mode | input | 2 | Personality: 0 gate, 1 XOR3, 2 latch, 3 flop |
| gateCfg | input | 8 | Tie selection for gate mode |
| a | input | 1 | Data pin; stage 0 select in gate mode, D in sequential modes |
| b | input | 1 | Data pin |
| c | input | 1 | Data pin; stage 1 select in gate mode |
| en | input | 1 | Latch enable, transparent when 1 |
| scanIn | input | 1 | Scan data input |
| scanEn | input | 1 | Scan enable, picks `scanIn` over `a` |
| out | output | 1 | Cell output |

## Verification
The assertions check on every cycle the parts that need no model of the chosen gate:

- the XOR3 identity;
- latch transparency and hold;
- the one-edge delay from the steered data input to `out` in flop mode;
- the zero output while clear is low;
- that the configuration stays still out of clear.

Only the bench scenarios can show the remaining behaviour:

- that each tie code in gate mode yields the intended gate across all input combinations;
- that clear acts immediately in the middle of a clock phase rather than at an edge;
- that clear is ignored in the combinational modes;
- that the output stays put when data moves while the clock is high.

// File: rtl/spareCellPkg.sv
package spareCellPkg;
  localparam int MODE_W = 2;
  localparam int TIE_W  = 2;
  localparam int NUM_TIES = 4;
  localparam int CFG_W  = NUM_TIES * TIE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_GATE  = 2'd0,
    MODE_XOR3  = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_FLOP  = 2'd3
  } modeT;

  // data source routed to a mux data input
  typedef enum logic [2:0] {
    SRC_ZERO, SRC_ONE, SRC_B, SRC_BN, SRC_DIN, SRC_ST0, SRC_ST0N, SRC_HOLD
  } srcT;

  // source routed to a mux select input
  typedef enum logic [2:0] {
    SEL_A, SEL_C, SEL_EN, SEL_CLK, SEL_ONE
  } selT;

  // routing strobes from control to datapath
  typedef struct packed {
    selT  sel0;
    srcT  lo0;
    srcT  hi0;
    selT  sel1;
    srcT  lo1;
    srcT  hi1;
    logic useScan;
    logic clrEn;
  } routeT;
endpackage

// File: rtl/spareMuxStage.sv
module spareMuxStage (
  input  logic sel,
  input  logic lo,
  input  logic hi,
  input  logic holdLo,
  input  logic holdHi,
  input  logic clrN,
  output logic q
);
  // a 2:1 mux whose held side is wired back to its own output
  always_latch begin
    if (!clrN)
      q = 1'b0;
    else if (sel ? !holdHi : !holdLo)
      q = sel ? hi : lo;
  end
endmodule

// File: rtl/spareCellCtrl.sv
module spareCellCtrl
  import spareCellPkg::*;
#(
  parameter int CFG_BITS = CFG_W
) (
  input  logic [MODE_W-1:0]   mode,
  input  logic [CFG_BITS-1:0] gateCfg,
  output routeT               route
);
  localparam int TIES = CFG_BITS / TIE_W;

  function automatic srcT tieFirst(input logic [TIE_W-1:0] code);
    case (code)
      2'd0:    tieFirst = SRC_ZERO;
      2'd1:    tieFirst = SRC_ONE;
      2'd2:    tieFirst = SRC_B;
      default: tieFirst = SRC_BN;
    endcase
  endfunction

  function automatic srcT tieSecond(input logic [TIE_W-1:0] code);
    case (code)
      2'd0:    tieSecond = SRC_ZERO;
      2'd1:    tieSecond = SRC_ONE;
      2'd2:    tieSecond = SRC_ST0;
      default: tieSecond = SRC_B;
    endcase
  endfunction

  logic [TIE_W-1:0] tieCode [TIES];

  for (genvar t = 0; t < TIES; t++) begin : gTie
    assign tieCode[t] = gateCfg[t*TIE_W +: TIE_W];
  end

  always_comb begin
    route = '{sel0: SEL_A, lo0: SRC_ZERO, hi0: SRC_ZERO,
              sel1: SEL_C, lo1: SRC_ST0, hi1: SRC_ST0,
              useScan: 1'b0, clrEn: 1'b0};
    case (modeT'(mode))
      MODE_GATE: begin
        route.lo0 = tieFirst(tieCode[0]);
        route.hi0 = tieFirst(tieCode[1]);
        route.lo1 = tieSecond(tieCode[2]);
        route.hi1 = tieSecond(tieCode[3]);
      end
      MODE_XOR3: begin
        route.lo0 = SRC_B;
        route.hi0 = SRC_BN;
        route.lo1 = SRC_ST0;
        route.hi1 = SRC_ST0N;
      end
      MODE_LATCH: begin
        route.sel0  = SEL_EN;
        route.lo0   = SRC_HOLD;
        route.hi0   = SRC_DIN;
        route.sel1  = SEL_ONE;
        route.hi1   = SRC_ST0;
        route.clrEn = 1'b1;
      end
      default: begin
        route.sel0    = SEL_CLK;
        route.lo0     = SRC_DIN;
        route.hi0     = SRC_HOLD;
        route.sel1    = SEL_CLK;
        route.lo1     = SRC_HOLD;
        route.hi1     = SRC_ST0;
        route.useScan = 1'b1;
        route.clrEn   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/spareCellPath.sv
module spareCellPath
  import spareCellPkg::*;
(
  input  logic  clk,
  input  logic  clrN,
  input  routeT route,
  input  logic  a,
  input  logic  b,
  input  logic  c,
  input  logic  en,
  input  logic  scanIn,
  input  logic  scanEn,
  output logic  out
);
  localparam int STAGES = 2;

  logic dataIn;
  logic bInv;
  logic stageClrN;
  logic st0;
  logic st1;
  logic selVal  [STAGES];
  logic loVal   [STAGES];
  logic hiVal   [STAGES];
  logic holdLo  [STAGES];
  logic holdHi  [STAGES];
  logic stageQ  [STAGES];
  selT  selSrc  [STAGES];
  srcT  loSrc   [STAGES];
  srcT  hiSrc   [STAGES];

  function automatic logic pickSel(input selT s, input logic pa, input logic pc,
                                   input logic pe, input logic pk);
    case (s)
      SEL_A:   pickSel = pa;
      SEL_C:   pickSel = pc;
      SEL_EN:  pickSel = pe;
      SEL_CLK: pickSel = pk;
      default: pickSel = 1'b1;
    endcase
  endfunction

  function automatic logic pickData(input srcT s, input logic pb, input logic pbn,
                                    input logic pd, input logic ps0);
    case (s)
      SRC_ONE:  pickData = 1'b1;
      SRC_B:    pickData = pb;
      SRC_BN:   pickData = pbn;
      SRC_DIN:  pickData = pd;
      SRC_ST0:  pickData = ps0;
      SRC_ST0N: pickData = ~ps0;
      default:  pickData = 1'b0;
    endcase
  endfunction

  assign bInv      = ~b;
  assign dataIn    = (route.useScan && scanEn) ? scanIn : a;
  assign stageClrN = clrN | ~route.clrEn;

  assign selSrc[0] = route.sel0;
  assign loSrc[0]  = route.lo0;
  assign hiSrc[0]  = route.hi0;
  assign selSrc[1] = route.sel1;
  assign loSrc[1]  = route.lo1;
  assign hiSrc[1]  = route.hi1;

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    assign selVal[s] = pickSel(selSrc[s], a, c, en, clk);
    assign loVal[s]  = pickData(loSrc[s], b, bInv, dataIn, st0);
    assign hiVal[s]  = pickData(hiSrc[s], b, bInv, dataIn, st0);
    assign holdLo[s] = (loSrc[s] == SRC_HOLD);
    assign holdHi[s] = (hiSrc[s] == SRC_HOLD);

    spareMuxStage uStage (
      .sel   (selVal[s]),
      .lo    (loVal[s]),
      .hi    (hiVal[s]),
      .holdLo(holdLo[s]),
      .holdHi(holdHi[s]),
      .clrN  (stageClrN),
      .q     (stageQ[s])
    );
  end

  assign st0 = stageQ[0];
  assign st1 = stageQ[1];
  assign out = st1;
endmodule

// File: rtl/spareCell.sv
module spareCell
  import spareCellPkg::*;
(
  input  logic             clk,
  input  logic             clrN,
  input  logic [MODE_W-1:0] mode,
  input  logic [CFG_W-1:0] gateCfg,
  input  logic             a,
  input  logic             b,
  input  logic             c,
  input  logic             en,
  input  logic             scanIn,
  input  logic             scanEn,
  output logic             out
);
  routeT route;

  spareCellCtrl #(.CFG_BITS(CFG_W)) uCtrl (
    .mode   (mode),
    .gateCfg(gateCfg),
    .route  (route)
  );

  spareCellPath uPath (
    .clk   (clk),
    .clrN  (clrN),
    .route (route),
    .a     (a),
    .b     (b),
    .c     (c),
    .en    (en),
    .scanIn(scanIn),
    .scanEn(scanEn),
    .out   (out)
  );
endmodule

// File: rtl/spareCellChecker.sv
module spareCellChecker
  import spareCellPkg::*;
(
  input logic             clk,
  input logic             clrN,
  input logic [MODE_W-1:0] mode,
  input logic [CFG_W-1:0] gateCfg,
  input logic             a,
  input logic             b,
  input logic             c,
  input logic             en,
  input logic             scanIn,
  input logic             scanEn,
  input logic             out
);
  AST_XOR3_PARITY: assert property (@(posedge clk) disable iff (!clrN)
    (mode == MODE_XOR3) |-> (out == (a ^ b ^ c))); // R2

  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!clrN)
    (mode == MODE_LATCH && en) |-> (out == a)); // R3

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!clrN)
    (mode == MODE_LATCH && !en && $past(mode) == MODE_LATCH && !$past(en) && $past(clrN))
      |-> $stable(out)); // R4

  AST_FLOP_CAPTURE: assert property (@(posedge clk) disable iff (!clrN)
    (mode == MODE_FLOP && $past(mode) == MODE_FLOP && $past(clrN))
      |-> (out == $past(scanEn ? scanIn : a))); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    (!clrN && (mode == MODE_LATCH || mode == MODE_FLOP)) |-> (out == 1'b0)); // R6

  AST_CFG_STATIC: assert property (@(posedge clk) disable iff (!clrN)
    $past(clrN) |-> ($stable(mode) && $stable(gateCfg))); // R8
endmodule

bind spareCell spareCellChecker uChk (
  .clk    (clk),
  .clrN   (clrN),
  .mode   (mode),
  .gateCfg(gateCfg),
  .a      (a),
  .b      (b),
  .c      (c),
  .en     (en),
  .scanIn (scanIn),
  .scanEn (scanEn),
  .out    (out)
);

// File: tb/spareCell_test.sv
module spareCell_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;
  localparam logic [7:0] CFG_TAB [8] = '{8'h88, 8'h66, 8'h9D, 8'h23,
                                         8'hA8, 8'hAE, 8'h68, 8'hE4};

  logic       clk = 1'b0;
  logic       clrN;
  logic [1:0] mode;
  logic [7:0] gateCfg;
  logic       a, b, c, en, scanIn, scanEn;
  logic       out;

  int checks = 0;
  int fails  = 0;
  int seedVal;

  spareCell uut (
    .clk(clk), .clrN(clrN), .mode(mode), .gateCfg(gateCfg),
    .a(a), .b(b), .c(c), .en(en), .scanIn(scanIn), .scanEn(scanEn),
    .out(out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: out=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // expected gate per configuration index
  function automatic logic gateExp(input int k, input logic x, input logic y, input logic z);
    case (k)
      0: gateExp = x & y & z;
      1: gateExp = x | y | z;
      2: gateExp = ~(x & y & z);
      3: gateExp = ~(x | y | z);
      4: gateExp = x & y;
      5: gateExp = x ^ y;
      6: gateExp = (x & y) | z;
      default: gateExp = z ? y : x;
    endcase
  endfunction

  task automatic setMode(input logic [1:0] m, input logic [7:0] cfg);
    @(negedge clk);
    clrN = 1'b0;
    mode = m;
    gateCfg = cfg;
    @(negedge clk);
    clrN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic held;
    logic expQ;
    seedVal = $urandom(32'd1234);
    clrN = 1'b0; mode = 2'd3; gateCfg = 8'h00;
    a = 1'b1; b = 1'b0; c = 1'b0; en = 1'b0; scanIn = 1'b1; scanEn = 1'b0;
    repeat (2) @(negedge clk);
    #1 chk("R6 reset state", out, 1'b0);

    // R1: gate personalities over all inputs
    for (int k = 0; k < 8; k++) begin
      setMode(2'd0, CFG_TAB[k]);
      for (int v = 0; v < 8; v++) begin
        @(negedge clk);
        a = v[0]; b = v[1]; c = v[2];
        #1 chk("R1 gate", out, gateExp(k, a, b, c));
      end
    end
    // R7: clear ignored in gate mode (NAND3 with all ones -> 0, all zero -> 1)
    setMode(2'd0, CFG_TAB[2]);
    @(negedge clk); a = 1'b0; b = 1'b0; c = 1'b0;
    @(negedge clk); clrN = 1'b0;
    #1 chk("R7 gate clear ignored", out, 1'b1);
    @(negedge clk); clrN = 1'b1;

    // R2: XOR3 exhaustive plus random
    setMode(2'd1, 8'h00);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      a = v[0]; b = v[1]; c = v[2];
      #1 chk("R2 xor3", out, ^v[2:0]);
    end
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      a = 1'($urandom); b = 1'($urandom); c = 1'($urandom);
      #1 chk("R2 xor3 random", out, a ^ b ^ c);
    end
    @(negedge clk); a = 1'b1; b = 1'b0; c = 1'b0; clrN = 1'b0;
    #1 chk("R7 xor clear ignored", out, 1'b1);
    @(negedge clk); clrN = 1'b1;

    // R3/R4: latch
    setMode(2'd2, 8'h00);
    en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      a = 1'($urandom);
      #1 chk("R3 latch transparent", out, a);
      #2 a = ~a;
      #1 chk("R3 latch follows mid-cycle", out, a);
    end
    @(negedge clk); a = 1'b1;
    @(negedge clk); en = 1'b0;
    held = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      a = ~a;
      #1 chk("R4 latch hold", out, held);
    end
    @(negedge clk); en = 1'b1; a = 1'b1;
    #1 chk("R3 latch reopen", out, 1'b1);
    #1 clrN = 1'b0;
    #1 chk("R6 latch clear over enable", out, 1'b0);
    @(negedge clk); clrN = 1'b1;
    #1 chk("R3 latch after clear", out, a);

    // R5: flop
    setMode(2'd3, 8'h00);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      a = 1'($urandom); scanIn = 1'($urandom); scanEn = 1'($urandom);
      expQ = scanEn ? scanIn : a;
      @(posedge clk);
      #1 chk("R5 flop capture", out, expQ);
      #2 a = ~a; scanIn = ~scanIn;
      #1 chk("R5 flop stable while clk high", out, expQ);
    end
    // directed: scan path then functional path
    @(negedge clk); a = 1'b0; scanIn = 1'b1; scanEn = 1'b1;
    @(posedge clk); #1 chk("R5 scan captured", out, 1'b1);
    @(negedge clk); a = 1'b0; scanIn = 1'b1; scanEn = 1'b0;
    @(posedge clk); #1 chk("R5 functional captured", out, 1'b0);
    @(negedge clk); a = 1'b1;
    @(posedge clk); #1 chk("R5 capture one", out, 1'b1);
    // R6: async clear mid low phase, held across an edge
    @(negedge clk); #2 clrN = 1'b0;
    #1 chk("R6 flop async clear", out, 1'b0);
    @(posedge clk); #1 chk("R6 clear beats clock", out, 1'b0);
    @(negedge clk); clrN = 1'b1; a = 1'b1; scanEn = 1'b0;
    #1 chk("R6 stays zero until edge", out, 1'b0);
    @(posedge clk); #1 chk("R5 capture after clear", out, 1'b1);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule